// File: doc/BRIEF.md
# Multi-Target Tuning Bus Master

This block drives one serial control bus that programs several tuning receivers. It takes an array of 8-bit words, one for each target, and a start request. It then shifts the words out on a serial clock that it derives from the system clock. Every target samples data on the rising edge of that clock and applies the new word when its enable line falls.

Two bus topologies can be selected while the block runs. In shared-data mode, all targets share the clock and one data line, and each target has its own enable. The master frames the targets one at a time in ascending index order, so the targets update one after another. A mask lets it skip targets in this mode. In common-enable mode, every target has its own data line and all targets share one enable. One frame shifts all words in parallel, and every target updates at the same enable fall. This mode always sends a word to every target, whatever the mask says.

Setup, hold and the enable-low gap between frames are counted in system cycles. Each of them is raised to at least one serial-clock half-period.

Top module: `tunebus_master`

## Requirements
- R1: After reset the block is quiet: `sclk`, `sdo`, `sdoLane`, `sen`, `senAll`, `busy` and `done` are all 0.
- R2: Each frame carries exactly 8 bits, most significant bit first. Each bit is sampled at a rising edge of `sclk`. The data lines change only while `sclk` is low, so they never change in a cycle where `sclk` is high.
- R3: `sclk` idles low. Each high phase and each low phase inside a frame lasts HALF_DIV system cycles. The defaults give 25 MHz from 100 MHz.
- R4: The active enable rises exactly SETUP_EFF cycles before the first `sclk` rise. `sclk` rises only while an enable is high. The enable falls with `sclk` low, exactly HOLD_EFF cycles after the last `sclk` fall.
- R5: In shared-data mode (`modeCommon`=0), the selected targets are framed in ascending index order. Each frame uses the one-hot enable `sen[i]` and puts the data on `sdo`. Meanwhile `senAll` and `sdoLane` stay 0.
- R6: In shared-data mode, target i is framed only if `enMask[i]`=1. If the mask is all zero, `done` pulses in the cycle after the start is accepted, `busy` stays low and no enable rises.
- R7: In common-enable mode (`modeCommon`=1), the block sends one frame under `senAll`. Lane i shifts word i on `sdoLane[i]`, with word i in `tgtWords[8i+7:8i]`. During this frame `sen` and `sdo` stay 0, and `enMask` is ignored.
- R8: Between successive frames of one run, the enable stays low for exactly GAP_EFF cycles.
- R9: A start request is ignored while `busy` is high. Mode, mask and words are captured in the cycle the start is accepted, so later changes to these inputs do not affect the run.
- R10: `busy` is high from the cycle after an accepted start until the run ends. `done` is a single-cycle pulse, with `busy` low, that comes exactly GAP_EFF cycles after the final enable fall. A start in the `done` cycle is accepted.
- R11: Configured setup, hold and gap values below HALF_DIV are raised to HALF_DIV. With the defaults, a hold of 1 becomes 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to program the targets |
| modeCommon | input | 1 | 0 = shared data with one enable per target, 1 = common enable with one data line per target |
| enMask | input | NUM_TGT | Per-target select for shared-data mode |
| tgtWords | input | NUM_TGT*WORD_W | Word i in bits [WORD_W*i+WORD_W-1 : WORD_W*i] |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Shared data line (shared-data mode) |
| sdoLane | output | NUM_TGT | Per-target data lines (common-enable mode) |
| sen | output | NUM_TGT | Per-target enables (shared-data mode) |
| senAll | output | 1 | Common enable (common-enable mode) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two functions can fall in the same cycle: the end-of-run `done` pulse and the acceptance of a new start request. The bench waits for the sample in which `done` is high and raises `startReq` in that very cycle. It then expects the new run to begin, with `busy` high and `done` low in the next sample, and the queued common-enable frame to appear on the bus. A second case overlaps a start request with a run in progress, while the mode, mask and words are also changed. The only frames the scoreboard may see are those of the first run.

// File: rtl/tunebus_pkg.sv
package tunebus_pkg;

  localparam int TGT_IDX_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } busState_t;

  typedef struct packed {
    logic                 capture;
    logic                 load;
    logic                 rise;
    logic                 fall;
    logic                 shift;
    logic                 drop;
    logic                 common;
    logic [TGT_IDX_W-1:0] tgt;
  } busStrobe_t;

endpackage

// File: rtl/tunebus_ctrl.sv
module tunebus_ctrl
  import tunebus_pkg::*;
#(
  parameter int NUM_TGT   = 4,
  parameter int WORD_W    = 8,
  parameter int HALF_DIV  = 2,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int GAP_CYC   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               modeCommon,
  input  logic [NUM_TGT-1:0] enMask,
  output busStrobe_t         stb,
  output logic               busy,
  output logic               done
);

  localparam int SETUP_EFF = (SETUP_CYC < HALF_DIV) ? HALF_DIV : SETUP_CYC;
  localparam int HOLD_EFF  = (HOLD_CYC  < HALF_DIV) ? HALF_DIV : HOLD_CYC;
  localparam int GAP_EFF   = (GAP_CYC   < HALF_DIV) ? HALF_DIV : GAP_CYC;
  localparam int MAX_AB    = (SETUP_EFF > HOLD_EFF) ? SETUP_EFF : HOLD_EFF;
  localparam int MAX_ABC   = (MAX_AB > GAP_EFF) ? MAX_AB : GAP_EFF;
  localparam int CNT_MAX   = (MAX_ABC > HALF_DIV) ? MAX_ABC : HALF_DIV;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int BIT_W     = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  busState_t            state, stateN;
  logic [CNT_W-1:0]     cnt, cntN;
  logic [BIT_W-1:0]     bitIdx, bitN;
  logic [TGT_IDX_W-1:0] tgt, tgtN;
  logic                 modeR, modeN;
  logic [NUM_TGT-1:0]   maskR, maskN;
  logic                 doneN;
  logic                 scanHit;
  logic [TGT_IDX_W-1:0] scanIdx;

  // Lowest selected target: from the live mask when idle, above the current one otherwise
  always_comb begin
    scanHit = 1'b0;
    scanIdx = '0;
    for (int i = NUM_TGT - 1; i >= 0; i--) begin
      if ((state == ST_IDLE) ? enMask[i]
                             : (maskR[i] && (TGT_IDX_W'(i) > tgt))) begin
        scanHit = 1'b1;
        scanIdx = TGT_IDX_W'(i);
      end
    end
  end

  always_comb begin
    stb        = '0;
    stb.common = modeR;
    stb.tgt    = tgt;
    stateN     = state;
    cntN       = cnt;
    bitN       = bitIdx;
    tgtN       = tgt;
    modeN      = modeR;
    maskN      = maskR;
    doneN      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          modeN       = modeCommon;
          maskN       = enMask;
          stb.capture = 1'b1;
          stb.common  = modeCommon;
          if (modeCommon || scanHit) begin
            tgtN     = modeCommon ? '0 : scanIdx;
            stb.tgt  = tgtN;
            stb.load = 1'b1;
            bitN     = '0;
            cntN     = CNT_W'(SETUP_EFF - 1);
            stateN   = ST_SETUP;
          end else begin
            doneN = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (cnt == '0) begin
          stb.rise = 1'b1;
          cntN     = CNT_W'(HALF_DIV - 1);
          stateN   = ST_HIGH;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      ST_HIGH: begin
        if (cnt == '0) begin
          stb.fall = 1'b1;
          if (bitIdx == BIT_W'(WORD_W - 1)) begin
            cntN   = CNT_W'(HOLD_EFF - 1);
            stateN = ST_HOLD;
          end else begin
            stb.shift = 1'b1;
            bitN      = bitIdx + 1'b1;
            cntN      = CNT_W'(HALF_DIV - 1);
            stateN    = ST_LOW;
          end
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      ST_LOW: begin
        if (cnt == '0) begin
          stb.rise = 1'b1;
          cntN     = CNT_W'(HALF_DIV - 1);
          stateN   = ST_HIGH;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt == '0) begin
          stb.drop = 1'b1;
          cntN     = CNT_W'(GAP_EFF - 1);
          stateN   = ST_GAP;
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt == '0) begin
          if (!modeR && scanHit) begin
            tgtN     = scanIdx;
            stb.tgt  = scanIdx;
            stb.load = 1'b1;
            bitN     = '0;
            cntN     = CNT_W'(SETUP_EFF - 1);
            stateN   = ST_SETUP;
          end else begin
            doneN  = 1'b1;
            stateN = ST_IDLE;
          end
        end else begin
          cntN = cnt - 1'b1;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      tgt    <= '0;
      modeR  <= 1'b0;
      maskR  <= '0;
      done   <= 1'b0;
    end else begin
      state  <= stateN;
      cnt    <= cntN;
      bitIdx <= bitN;
      tgt    <= tgtN;
      modeR  <= modeN;
      maskR  <= maskN;
      done   <= doneN;
    end
  end

  assign busy = (state != ST_IDLE);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> (modeR == $past(modeR) && maskR == $past(maskR)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done || $past(startReq)));

endmodule

// File: rtl/tunebus_dp.sv
module tunebus_dp
  import tunebus_pkg::*;
#(
  parameter int NUM_TGT = 4,
  parameter int WORD_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busStrobe_t                stb,
  input  logic [NUM_TGT*WORD_W-1:0] tgtWords,
  output logic                      sclk,
  output logic                      sdo,
  output logic [NUM_TGT-1:0]        sdoLane,
  output logic [NUM_TGT-1:0]        sen,
  output logic                      senAll
);

  localparam int WORDS_W = NUM_TGT * WORD_W;

  logic [WORDS_W-1:0] wordsR;
  logic [WORDS_W-1:0] wordsSrc;
  logic [WORD_W-1:0]  selWord;
  logic [WORD_W-1:0]  sharedSh;

  assign wordsSrc = stb.capture ? tgtWords : wordsR;

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (stb.tgt == TGT_IDX_W'(i)) selWord = wordsSrc[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordsR   <= '0;
      sclk     <= 1'b0;
      sen      <= '0;
      senAll   <= 1'b0;
      sharedSh <= '0;
    end else begin
      if (stb.capture) wordsR <= tgtWords;
      if (stb.rise) sclk <= 1'b1;
      else if (stb.fall) sclk <= 1'b0;
      if (stb.drop) begin
        sen      <= '0;
        senAll   <= 1'b0;
        sharedSh <= '0;
      end else if (stb.load) begin
        if (stb.common) begin
          senAll <= 1'b1;
        end else begin
          for (int i = 0; i < NUM_TGT; i++) sen[i] <= (stb.tgt == TGT_IDX_W'(i));
          sharedSh <= selWord;
        end
      end else if (stb.shift) begin
        sharedSh <= {sharedSh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sdo = sharedSh[WORD_W-1];

  for (genvar g = 0; g < NUM_TGT; g++) begin : gLane
    logic [WORD_W-1:0] laneSh;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneSh <= '0;
      end else if (stb.drop) begin
        laneSh <= '0;
      end else if (stb.load && stb.common) begin
        laneSh <= wordsSrc[g*WORD_W +: WORD_W];
      end else if (stb.shift) begin
        laneSh <= {laneSh[WORD_W-2:0], 1'b0};
      end
    end
    assign sdoLane[g] = laneSh[WORD_W-1];
  end

  // R2
  data_high_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable({sdo, sdoLane}));

  // R4
  rise_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> ((|sen) || senAll));

  // R4
  en_fall_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell((|sen) || senAll) |-> !sclk);

  // R5
  one_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sen) && !(senAll && (|sen)));

endmodule

// File: rtl/tunebus_master.sv
module tunebus_master
  import tunebus_pkg::*;
#(
  parameter int NUM_TGT   = 4,
  parameter int WORD_W    = 8,
  parameter int HALF_DIV  = 2,
  parameter int SETUP_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int GAP_CYC   = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startReq,
  input  logic                      modeCommon,
  input  logic [NUM_TGT-1:0]        enMask,
  input  logic [NUM_TGT*WORD_W-1:0] tgtWords,
  output logic                      sclk,
  output logic                      sdo,
  output logic [NUM_TGT-1:0]        sdoLane,
  output logic [NUM_TGT-1:0]        sen,
  output logic                      senAll,
  output logic                      busy,
  output logic                      done
);

  busStrobe_t stb;

  tunebus_ctrl #(
    .NUM_TGT(NUM_TGT), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV),
    .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeCommon(modeCommon),
    .enMask(enMask), .stb(stb), .busy(busy), .done(done)
  );

  tunebus_dp #(
    .NUM_TGT(NUM_TGT), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtWords(tgtWords),
    .sclk(sclk), .sdo(sdo), .sdoLane(sdoLane), .sen(sen), .senAll(senAll)
  );

endmodule

// File: tb/tunebus_master_bench.sv
module tunebus_master_bench;

  localparam int N        = 4;
  localparam int W        = 8;
  localparam int HALF     = 2;
  localparam int SETUP    = 3;
  localparam int HOLD     = 1;
  localparam int GAP      = 5;
  localparam int SETUP_EFF = (SETUP < HALF) ? HALF : SETUP;
  localparam int HOLD_EFF  = (HOLD  < HALF) ? HALF : HOLD;
  localparam int GAP_EFF   = (GAP   < HALF) ? HALF : GAP;

  typedef struct packed {
    logic         common;
    logic [7:0]   tgt;
    logic [N*W-1:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rstN;
  logic startReq;
  logic modeCommon;
  logic [N-1:0] enMask;
  logic [N*W-1:0] tgtWords;
  logic sclk, sdo, senAll, busy, done;
  logic [N-1:0] sdoLane, sen;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  item_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tunebus_master #(
    .NUM_TGT(N), .WORD_W(W), .HALF_DIV(HALF),
    .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .GAP_CYC(GAP)
  ) u_tunebus_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .modeCommon(modeCommon),
    .enMask(enMask), .tgtWords(tgtWords), .sclk(sclk), .sdo(sdo),
    .sdoLane(sdoLane), .sen(sen), .senAll(senAll), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor state
  logic prevSclk = 0, prevEn = 0, prevBusy = 0;
  logic [N:0] prevData = '0;
  bit frameCommon;
  int frameTgt;
  int bitsCnt;
  logic [W-1:0] capShared;
  logic [N*W-1:0] capLane;
  int tEnRise = 0, tRise = 0, tFall = 0, tEnFall = -1000;

  always @(negedge clk) begin
    if (!rstN) begin
      prevSclk = 0; prevEn = 0; prevBusy = 0; prevData = '0;
    end else begin
      logic enNow;
      enNow = (|sen) || senAll;
      if (sclk && ({sdo, sdoLane} != prevData))
        chk(0, "R2", "data moved while sclk high", {sdo, sdoLane}, prevData);
      if (!prevEn && enNow) begin
        if (prevBusy && busy)
          chk(cyc - tEnFall == GAP_EFF, "R8", "enable low gap", cyc - tEnFall, GAP_EFF);
        tEnRise = cyc; bitsCnt = 0; capShared = '0; capLane = '0;
        if (senAll) begin
          frameCommon = 1;
          chk(sen == '0 && sdo == 1'b0, "R7", "per-target enables/shared data idle",
              {sen, sdo}, 0);
        end else begin
          frameCommon = 0;
          frameTgt = 0;
          for (int i = 0; i < N; i++) if (sen[i]) frameTgt = i;
          chk($onehot(sen) && sdoLane == '0, "R5", "one-hot enable, lanes idle",
              {sen, sdoLane}, (1 << frameTgt) << N);
        end
      end
      if (!prevSclk && sclk) begin
        if (!enNow) chk(0, "R4", "sclk rose without enable", 0, 1);
        if (bitsCnt == 0)
          chk(cyc - tEnRise == SETUP_EFF, "R4", "enable to first rise", cyc - tEnRise, SETUP_EFF);
        else
          chk(cyc - tFall == HALF, "R3", "low phase length", cyc - tFall, HALF);
        capShared = {capShared[W-2:0], sdo};
        for (int i = 0; i < N; i++)
          capLane[i*W +: W] = {capLane[i*W +: W-1], sdoLane[i]};
        bitsCnt++;
        tRise = cyc;
      end
      if (prevSclk && !sclk) begin
        chk(cyc - tRise == HALF, "R3", "high phase length", cyc - tRise, HALF);
        tFall = cyc;
      end
      if (prevEn && !enNow) begin
        chk(!sclk && (cyc - tFall == HOLD_EFF), "R11", "hold after last fall (R4)",
            cyc - tFall, HOLD_EFF);
        chk(bitsCnt == W, "R2", "bits per frame", bitsCnt, W);
        tEnFall = cyc;
        if (expQ.size() == 0) begin
          chk(0, "R9", "unexpected frame", frameTgt, 0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          if (e.common) begin
            chk(frameCommon == 1, "R7", "frame mode", frameCommon, 1);
            chk(capLane == e.data, "R7", "lane words", capLane, e.data);
          end else begin
            chk(frameCommon == 0 && frameTgt == int'(e.tgt), "R5", "target order",
                frameTgt, e.tgt);
            chk(capShared == e.data[W-1:0], "R2", "shared word MSB first",
                capShared, e.data[W-1:0]);
          end
        end
      end
      prevSclk = sclk; prevEn = enNow; prevBusy = busy; prevData = {sdo, sdoLane};
    end
  end

  // Driver: queue the expected frames, then pulse the start request (called at a negedge)
  task automatic startRun(input bit common, input logic [N-1:0] mask,
                          input logic [N*W-1:0] words);
    int nExp = 0;
    if (common) begin
      expQ.push_back('{common: 1'b1, tgt: 8'd0, data: words});
      nExp = 1;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (mask[i]) begin
          expQ.push_back('{common: 1'b0, tgt: 8'(i), data: (N*W)'(words[i*W +: W])});
          nExp++;
        end
      end
    end
    modeCommon = common; enMask = mask; tgtWords = words; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (nExp > 0) begin
      chk(busy == 1'b1, "R10", "busy after start", busy, 1);
      chk(done == 1'b0, "R10", "done low after start", done, 0);
    end else begin
      chk(done == 1'b1 && busy == 1'b0, "R6", "empty mask done pulse", {done, busy}, 2);
      chk(sen == '0 && senAll == 1'b0, "R6", "no enable for empty mask", {sen, senAll}, 0);
      @(negedge clk);
      chk(done == 1'b0, "R6", "done single cycle", done, 0);
    end
  endtask

  task automatic waitDone(input bit checkLow);
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
    chk(expQ.size() == 0, "R10", "frames outstanding at done", expQ.size(), 0);
    chk(cyc - tEnFall == GAP_EFF, "R10", "done after last enable fall", cyc - tEnFall, GAP_EFF);
    if (checkLow) begin
      @(negedge clk);
      chk(done == 1'b0, "R10", "done single cycle", done, 0);
    end
  endtask

  initial begin
    rstN = 1'b0; startReq = 1'b0; modeCommon = 1'b0; enMask = '0; tgtWords = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sclk == 0 && sdo == 0 && sdoLane == 0, "R1", "bus lines after reset", {sclk, sdo, sdoLane}, 0);
    chk(sen == 0 && senAll == 0, "R1", "enables after reset", {sen, senAll}, 0);
    chk(busy == 0 && done == 0, "R1", "status after reset", {busy, done}, 0);

    // R5 all targets in shared-data mode
    startRun(1'b0, 4'hF, 32'h01F03CA5);
    waitDone(1'b1);
    // R6 masked targets skipped
    startRun(1'b0, 4'b1010, 32'h11223344);
    waitDone(1'b1);
    // R6 empty mask
    startRun(1'b0, 4'b0000, 32'hAAAAAAAA);
    // R7 common-enable mode, mask ignored
    startRun(1'b1, 4'b0001, 32'hFF007E81);
    waitDone(1'b1);
    // R9 start, mode, mask and words changed while busy
    startRun(1'b0, 4'b0101, 32'hDEADBEEF);
    repeat (30) @(negedge clk);
    modeCommon = 1'b1; enMask = 4'hF; tgtWords = 32'h12345678; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone(1'b0);
    // R10 start in the done cycle is accepted
    startRun(1'b1, 4'h0, 32'hC3A55A3C);
    waitDone(1'b1);

    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule